// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers level-sensitive interrupt requests from a set of bus device slots and folds them onto a small number of shared interrupt output lines. Every slot has four request pins. A fixed routing rule assigns each pin to one output line. The rule rotates the pin index by the slot number, so that devices which use only their first pin still spread across all of the lines.

The block does not compute a plain OR. It keeps a registered copy of every pin's last level and turns each edge into an event: +1 on a rise, -1 on a fall. For each output line it holds a counter of the pins currently asserting that line. A line is driven high while its counter is nonzero. Events from any number of pins in one cycle are added into each counter in that same cycle. The interface is a plain level vector in and a plain level vector out. It carries no stream data, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_share_agg`

## Requirements
- R1: After reset, every line counter and every stored pin level is zero, and `line_irq_o` is all zero.
- R2: Pin p (0..3) of slot s is routed to output line (s + p) mod NUM_LINES.
- R3: A pin whose input level equals its stored level changes no counter, and so leaves `line_irq_o` unchanged.
- R4: A rising pin adds one to its routed line's counter and a falling pin subtracts one; the stored level takes the new value. Both take effect one clock after the input is sampled.
- R5: Output line k is high exactly when its counter is nonzero, and it changes one clock after the pin edge that changes the counter.
- R6: Edges from several pins and slots in the same cycle, including a rise and a fall on one line, are all applied to the counters in that cycle, and none is lost.
- R7: Counters are wide enough that all 4*NUM_SLOTS pins asserting one line cannot overflow. Each counter never exceeds the number of pins routed to its line.
- R8: The pin input is laid out as slot s pin p at bit 4*s+p of `pin_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl_i | input | 4*NUM_SLOTS | Request pin levels; bit 4*s+p is slot s pin p |
| line_irq_o | output | NUM_LINES | Shared interrupt line levels |

## Verification
Single walking pins test the routing rule one pin at a time, because a wrong swizzle raises the wrong line. Holding a pin at a steady level shows whether the stored-level compare suppresses repeat events. Several pins that share one line, released in different orders, check the counting against a plain OR: the line must stay high until the last pin falls. Random vectors that flip many pins per cycle, including a rise and a fall on the same line together, check that simultaneous events are summed and none is dropped.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int unsigned PINS_PER_SLOT = 4;

  function automatic int unsigned route_line(int unsigned slot, int unsigned pin,
                                             int unsigned lines);
    return (slot + pin) % lines;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned LINE_IDX  = 0,
  localparam int unsigned NPINS = 4 * NUM_SLOTS,
  localparam int unsigned CW    = $clog2(NPINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  output logic [CW-1:0]    cnt_o,
  output logic             busy_o
);
  import irq_share_pkg::*;

  // Pins that are routed to this line.
  logic [NPINS-1:0] sel;
  for (genvar g = 0; g < NPINS; g++) begin : g_sel
    assign sel[g] = (route_line(g / PINS_PER_SLOT, g % PINS_PER_SLOT, NUM_LINES)
                     == LINE_IDX);
  end

  logic [CW-1:0] ups, downs, cnt_q;
  always_comb begin
    ups   = '0;
    downs = '0;
    for (int i = 0; i < NPINS; i++) begin
      ups   = ups   + CW'(rise_i[i] & sel[i]);
      downs = downs + CW'(fall_i[i] & sel[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + ups - downs;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned NPINS = 4 * NUM_SLOTS,
  localparam int unsigned CW    = $clog2(NPINS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_lvl_i,
  output logic [NUM_LINES-1:0] line_irq_o
);
  logic [NPINS-1:0] rise, fall;
  logic [NUM_LINES-1:0][CW-1:0] line_cnt;

  irq_pin_edge #(.WIDTH(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_lvl_i),
    .rise_o(rise), .fall_o(fall)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    irq_line_counter #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES), .LINE_IDX(k)
    ) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
      .cnt_o(line_cnt[k]), .busy_o(line_irq_o[k])
    );
  end
endmodule

// File: rtl/irq_share_agg_chk.sv
module irq_share_agg_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned NPINS = 4 * NUM_SLOTS,
  localparam int unsigned CW    = $clog2(NPINS + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPINS-1:0]             pin_lvl_i,
  input logic [NUM_LINES-1:0]         line_irq_o,
  input logic [NUM_LINES-1:0][CW-1:0] line_cnt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (line_irq_o == '0));
  // R3
  steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_lvl_i) |=> $stable(line_irq_o));
  // R5
  out_follows_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_irq_o == '0) == (line_cnt == '0));
  // R7
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_ov
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_cnt[k] <= CW'(NPINS));
  end
  // R4
  all_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl_i == '0) |=> (line_irq_o == '0));
endmodule

bind irq_share_agg irq_share_agg_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin_lvl_i),
  .line_irq_o(line_irq_o), .line_cnt(line_cnt)
);

// File: tb/test_irq_share_agg.sv
`timescale 1ns/1ps
module test_irq_share_agg;
  localparam int NS = 8;
  localparam int NL = 4;
  localparam int NP = 4 * NS;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0] pins = '0;
  logic [NL-1:0] lines;

  int n_tests = 0, n_fail = 0;
  int cnt [NL];
  bit prev [NP];
  bit checking = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  irq_share_agg #(.NUM_SLOTS(NS), .NUM_LINES(NL)) i_irq_share_agg (
    .clk(clk), .rst_n(rst_n), .pin_lvl_i(pins), .line_irq_o(lines)
  );

  // Behavioural model: count per line, pin k -> line (k/4 + k%4) % NL (R2, R8).
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cnt[i]) cnt[i] = 0;
      foreach (prev[i]) prev[i] = 0;
    end else begin
      for (int k = 0; k < NP; k++) begin
        if (pins[k] != prev[k]) begin
          cnt[(k/4 + k%4) % NL] += pins[k] ? 1 : -1;
          prev[k] = pins[k];
        end
      end
    end
  end

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] e;
    for (int i = 0; i < NL; i++) e[i] = (cnt[i] != 0);
    return e;
  endfunction

  // Compare every cycle at the falling edge (R5, R6).
  always @(negedge clk) begin
    if (checking) begin
      n_tests++;
      if (lines !== exp_lines()) begin
        n_fail++;
        $display("FAIL %s: line_irq_o=%b expected=%b", cur_req, lines, exp_lines());
      end
    end
  end

  task automatic step(input logic [NP-1:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic expect_lines(input string req, input logic [NL-1:0] e);
    @(negedge clk);
    #0.1;
    n_tests++;
    if (lines !== e) begin
      n_fail++;
      $display("FAIL %s: line_irq_o=%b expected=%b", req, lines, e);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    expect_lines("R1", '0);
    checking = 1;

    // R2 / R8: walk each pin alone; line = (s+p)%NL
    cur_req = "R2";
    for (int k = 0; k < NP; k++) begin
      step(NP'(1) << k);
      expect_lines("R2", NL'(1) << ((k/4 + k%4) % NL));
    end
    step('0);
    expect_lines("R2", '0);

    // R3: hold level steady, output unchanged
    cur_req = "R3";
    step(NP'(1) << 5);          // slot1 pin1 -> line 2
    repeat (4) expect_lines("R3", 4'b0100);

    // R4/R5: two pins share line 0 (slot0 pin0 bit0, slot1 pin3 bit7)
    cur_req = "R4";
    step(NP'(1) | (NP'(1) << 7));
    expect_lines("R4", 4'b0001);
    step(NP'(1) << 7);          // one falls, line stays
    expect_lines("R4", 4'b0001);
    step('0);
    expect_lines("R5", 4'b0000);

    // R6: simultaneous rise and fall on same line 0
    cur_req = "R6";
    step(NP'(1));               // bit0 high
    expect_lines("R6", 4'b0001);
    step(NP'(1) << 7);          // bit0 falls, bit7 rises together
    expect_lines("R6", 4'b0001);
    step('0);
    expect_lines("R6", 4'b0000);

    // R7: all pins high, then all low
    cur_req = "R7";
    step('1);
    expect_lines("R7", 4'b1111);
    step('0);
    expect_lines("R7", 4'b0000);

    // R6: random many-pin toggles, model compared every cycle
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      v = {$urandom, $urandom};
      step(v);
    end
    step('0);
    expect_lines("R6", '0);

    // R1: reset mid-activity clears state
    step('1);
    @(negedge clk);
    rst_n = 0;
    pins = '0;
    @(negedge clk);
    rst_n = 1;
    expect_lines("R1", '0);

    checking = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule